// File: doc/BRIEF.md
# Daisy-Chained Bus Interrupter

This block lets a card on an asynchronous backplane raise a prioritized interrupt and identify itself. A pulse on the local event input sets a pending request. The request is driven on whichever of the seven active-low request lines matches the configured level. A level setting of zero drives no line at all.

When the interrupt handler runs an acknowledge cycle, the acknowledge arrives on the chain input, the acknowledged level arrives on a 3-bit field, and the data strobes are asserted. The block then does one of two things:
- If it has a request pending at that level, it answers with its 8-bit identity vector and data acknowledge.
- Otherwise it forwards the acknowledge on its chain output to the next slot.

Because a slot that answers does not forward, the card nearer the head of the chain is served first.

Clearing is set by configuration. In release-on-acknowledge mode, accepting the acknowledge clears the request. In release-on-register-access mode, the request stays up until the local clear-register access strobe is pulsed. All bus inputs are taken as already synchronized to `clk`.

Top module: `bus_interrupter`

## Requirements
- R1: After reset all request lines are high, the chain output and data acknowledge are high, and the data enable is low.
- R2: One cycle after an event pulse, request line bit (level-1) is low and all other bits are high; a level of 0 drives no request line.
- R3: The block accepts an acknowledge when the chain input is low, a strobe is low (either bit of `ds_n`), the acknowledged level equals the configured level, and a request is pending. In the cycle after acceptance, data acknowledge is low, the data enable is high, the data bus carries the vector, and the chain output stays high.
- R4: The block forwards instead when the chain input is low, a strobe is low, and the level differs or nothing is pending. In that case the chain output goes low one cycle later and data acknowledge stays high.
- R5: A low chain output returns high one cycle after the chain input goes high.
- R6: Data acknowledge and the data enable are removed one cycle after both strobes are high.
- R7: In release-on-acknowledge mode (`release_on_ack`=1), the request is cleared at acceptance, so request lines are all high from the first answering cycle.
- R8: In release-on-register-access mode (`release_on_ack`=0), the request survives the acknowledge and is cleared one cycle after a `clr_access` pulse.
- R9: In release-on-acknowledge mode a `clr_access` pulse has no effect on the request.
- R10: An event in the same cycle as a clear (by access or by acceptance) leaves the request pending.
- R11: If two chained interrupters pend on the same level, the upstream one answers and the downstream one sees a high chain input. On the next acknowledge, the upstream one forwards and the downstream one answers one cycle after its chain input falls.
- R12: A low chain input with both strobes high causes neither forwarding nor an answer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_level | input | 3 | Request level 1..7, 0 = disabled |
| cfg_vector | input | 8 | Identity vector returned on acknowledge |
| release_on_ack | input | 1 | 1 = clear on acknowledge, 0 = clear on register access |
| event_pulse | input | 1 | Local event, sets the request |
| clr_access | input | 1 | Local clear-register access strobe |
| irq_n | output | 7 | Active-low request lines, bit k = level k+1 |
| iack_in_n | input | 1 | Acknowledge chain input, active low |
| iack_out_n | output | 1 | Acknowledge chain output, active low |
| iack_lvl | input | 3 | Acknowledged level from address bits 3..1 |
| ds_n | input | 2 | Data strobes, active low |
| dtack_n | output | 1 | Data acknowledge, active low |
| data_out | output | 8 | Vector byte |
| data_oe | output | 1 | Data bus drive enable |

## Verification
Two functions collide in one cycle: setting the request from a local event, and clearing it. The clear can come from the register-access strobe in one mode, or from acceptance of an acknowledge in the other. The bench provokes both collisions by pulsing the event in the exact cycle of the clear access, and in the cycle the acknowledge is accepted. It judges the outcome by whether the request line is still low afterwards. A second chained instance shows the slot order when two interrupters pend on one level.

// File: rtl/irq_chain_pkg.sv
// Shared types for the bus interrupter.
package irq_chain_pkg;
    // Acknowledge-chain controller states
    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,   // waiting for an acknowledge
        CH_PASS  = 2'd1,   // forwarding the chain downstream
        CH_REPLY = 2'd2,   // driving vector and data acknowledge
        CH_DONE  = 2'd3    // answered, waiting for chain input release
    } chain_state_t;
endpackage

// File: rtl/irq_request.sv
// Pending-request flag and request-line drivers.
// Assumes: all inputs synchronous to clk; level 0 disables the request lines.
// When a set and a clear fall in one cycle, the set wins, so no event is lost.
module irq_request #(
    parameter int NUM_LEVELS = 7,
    parameter int LVL_W      = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  event_i,
    input  logic                  clr_access_i,
    input  logic                  ack_take_i,
    input  logic                  release_on_ack_i,
    input  logic [LVL_W-1:0]      level_i,
    output logic                  pend_o,
    output logic [NUM_LEVELS-1:0] irq_n_o
);
    logic pend_q;
    logic clear_now;

    // Select the clear source for the configured release policy
    always_comb begin
        clear_now = release_on_ack_i ? ack_take_i : clr_access_i;
    end

    // Pending flag: set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (event_i)
            pend_q <= 1'b1;
        else if (clear_now)
            pend_q <= 1'b0;
    end

    assign pend_o = pend_q;

    // One active-low driver per level
    for (genvar k = 0; k < NUM_LEVELS; k++) begin : g_line
        assign irq_n_o[k] = !(pend_q && (level_i == LVL_W'(k + 1)));
    end

    // R10: an event always leaves the request pending
    p_event_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
        event_i |=> pend_q);

    // R8: with register-access release, only the access clears
    p_rora_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !release_on_ack_i && !clr_access_i) |=> pend_q);

    // R9: with acknowledge release, a register access does not clear
    p_roak_no_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && release_on_ack_i && !ack_take_i) |=> pend_q);
endmodule

// File: rtl/iack_chain.sv
// Acknowledge daisy-chain controller.
// The controller decides once per acknowledge cycle whether to answer or forward.
// Answer: drive vector and data acknowledge until the strobes release.
// Forward: hold the chain output low until the chain input releases.
// Assumes: inputs already synchronized to clk.
module iack_chain
    import irq_chain_pkg::*;
#(
    parameter int LVL_W = 3,
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iack_in_n,
    input  logic             strobe_i,
    input  logic [LVL_W-1:0] ack_lvl_i,
    input  logic [LVL_W-1:0] level_i,
    input  logic             pend_i,
    input  logic [VEC_W-1:0] vector_i,
    output logic             take_o,
    output logic             iack_out_n,
    output logic             dtack_n,
    output logic [VEC_W-1:0] data_o,
    output logic             data_oe
);
    chain_state_t state_q, state_d;
    logic [VEC_W-1:0] vec_q;
    logic ack_seen;
    logic match;

    // Decode the acknowledge and the level match
    always_comb begin
        ack_seen = !iack_in_n && strobe_i;
        match    = pend_i && (level_i != '0) && (ack_lvl_i == level_i);
        take_o   = (state_q == CH_IDLE) && ack_seen && match;
    end

    // Next-state logic of the chain controller
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE:  if (ack_seen) state_d = match ? CH_REPLY : CH_PASS;
            CH_PASS:  if (iack_in_n) state_d = CH_IDLE;
            CH_REPLY: if (!strobe_i) state_d = iack_in_n ? CH_IDLE : CH_DONE;
            CH_DONE:  if (iack_in_n) state_d = CH_IDLE;
            default:  state_d = CH_IDLE;
        endcase
    end

    // State register and vector capture at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
            vec_q   <= '0;
        end else begin
            state_q <= state_d;
            if (take_o) vec_q <= vector_i;
        end
    end

    // Output decode from the state register
    always_comb begin
        iack_out_n = (state_q != CH_PASS);
        dtack_n    = (state_q != CH_REPLY);
        data_oe    = (state_q == CH_REPLY);
        data_o     = (state_q == CH_REPLY) ? vec_q : '0;
    end

    // R4: the chain output only falls after a strobed acknowledge input
    p_pass_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(iack_out_n) |-> $past(!iack_in_n && strobe_i));

    // R5: a released chain input releases the chain output next cycle
    p_chain_return_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!iack_out_n && iack_in_n) |=> iack_out_n);

    // R6: released strobes remove the data acknowledge next cycle
    p_dtack_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!dtack_n && !strobe_i) |=> (dtack_n && !data_oe));
endmodule

// File: rtl/bus_interrupter.sv
// Top of the bus interrupter.
// Joins the pending-request logic and the acknowledge chain controller.
// A strobe counts as asserted when either data strobe is low.
// Assumes: bus inputs synchronized to clk; synchronous active-low reset.
module bus_interrupter #(
    parameter int NUM_LEVELS = 7,
    parameter int VEC_W      = 8,
    localparam int LVL_W     = $clog2(NUM_LEVELS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [LVL_W-1:0]      cfg_level,
    input  logic [VEC_W-1:0]      cfg_vector,
    input  logic                  release_on_ack,
    input  logic                  event_pulse,
    input  logic                  clr_access,
    output logic [NUM_LEVELS-1:0] irq_n,
    input  logic                  iack_in_n,
    output logic                  iack_out_n,
    input  logic [LVL_W-1:0]      iack_lvl,
    input  logic [1:0]            ds_n,
    output logic                  dtack_n,
    output logic [VEC_W-1:0]      data_out,
    output logic                  data_oe
);
    logic strobe;
    logic pend;
    logic take;

    // Either strobe low marks the data phase
    assign strobe = !(&ds_n);

    irq_request #(.NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W)) u_req (
        .clk              (clk),
        .rst_n            (rst_n),
        .event_i          (event_pulse),
        .clr_access_i     (clr_access),
        .ack_take_i       (take),
        .release_on_ack_i (release_on_ack),
        .level_i          (cfg_level),
        .pend_o           (pend),
        .irq_n_o          (irq_n)
    );

    iack_chain #(.LVL_W(LVL_W), .VEC_W(VEC_W)) u_chain (
        .clk        (clk),
        .rst_n      (rst_n),
        .iack_in_n  (iack_in_n),
        .strobe_i   (strobe),
        .ack_lvl_i  (iack_lvl),
        .level_i    (cfg_level),
        .pend_i     (pend),
        .vector_i   (cfg_vector),
        .take_o     (take),
        .iack_out_n (iack_out_n),
        .dtack_n    (dtack_n),
        .data_o     (data_out),
        .data_oe    (data_oe)
    );

    // R4: never forward and answer at once
    p_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!iack_out_n && !dtack_n));

    // R7: entering the answer under acknowledge release leaves nothing pending
    p_roak_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (take && release_on_ack && !event_pulse) |=> (!pend && !dtack_n));
endmodule

// File: tb/bus_interrupter_test.sv
// Directed bench: two chained interrupters, uut upstream of uut_far.
module bus_interrupter_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic [2:0] lvl_a = 3'd0, lvl_b = 3'd0, ack_lvl = 3'd0;
    logic [7:0] vec_a = 8'h00, vec_b = 8'h00;
    logic       roak_a = 1'b1, roak_b = 1'b0;
    logic       ev_a = 1'b0, ev_b = 1'b0, clr_a = 1'b0, clr_b = 1'b0;
    logic       iack_head = 1'b1;
    logic [1:0] ds = 2'b11;
    logic [6:0] irq_a, irq_b;
    logic       chain, chain_end, dtack_a, dtack_b, oe_a, oe_b;
    logic [7:0] data_a, data_b;

    int checks = 0;
    int errors = 0;

    bus_interrupter uut (
        .clk(clk), .rst_n(rst_n), .cfg_level(lvl_a), .cfg_vector(vec_a),
        .release_on_ack(roak_a), .event_pulse(ev_a), .clr_access(clr_a),
        .irq_n(irq_a), .iack_in_n(iack_head), .iack_out_n(chain),
        .iack_lvl(ack_lvl), .ds_n(ds), .dtack_n(dtack_a),
        .data_out(data_a), .data_oe(oe_a)
    );

    bus_interrupter uut_far (
        .clk(clk), .rst_n(rst_n), .cfg_level(lvl_b), .cfg_vector(vec_b),
        .release_on_ack(roak_b), .event_pulse(ev_b), .clr_access(clr_b),
        .irq_n(irq_b), .iack_in_n(chain), .iack_out_n(chain_end),
        .iack_lvl(ack_lvl), .ds_n(ds), .dtack_n(dtack_b),
        .data_out(data_b), .data_oe(oe_b)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Advance one clock; return just after the edge
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic pulse_event_a();
        ev_a = 1'b1; step(); ev_a = 1'b0;
    endtask

    task automatic end_cycle();
        ds = 2'b11; step(); iack_head = 1'b1; step(); step();
    endtask

    task automatic t_reset();
        check("R1 irq", {25'd0, irq_a}, 32'h7f);
        check("R1 chain", {31'd0, chain}, 32'd1);
        check("R1 dtack", {31'd0, dtack_a}, 32'd1);
        check("R1 oe", {31'd0, oe_a}, 32'd0);
    endtask

    task automatic t_raise();
        lvl_a = 3'd3; roak_a = 1'b1; pulse_event_a();
        check("R2 level3", {25'd0, irq_a}, 32'h7b);
        lvl_b = 3'd0; roak_b = 1'b0; ev_b = 1'b1; step(); ev_b = 1'b0;
        check("R2 level0", {25'd0, irq_b}, 32'h7f);
        clr_b = 1'b1; step(); clr_b = 1'b0;
    endtask

    task automatic t_ack_match();
        vec_a = 8'hA5; ack_lvl = 3'd3; iack_head = 1'b0; ds = 2'b10; step();
        check("R3 dtack", {31'd0, dtack_a}, 32'd0);
        check("R3 data", {24'd0, data_a}, 32'hA5);
        check("R3 oe", {31'd0, oe_a}, 32'd1);
        check("R3 chain", {31'd0, chain}, 32'd1);
        check("R7 cleared", {25'd0, irq_a}, 32'h7f);
        ds = 2'b11; step();
        check("R6 dtack", {31'd0, dtack_a}, 32'd1);
        check("R6 oe", {31'd0, oe_a}, 32'd0);
        iack_head = 1'b1; step(); step();
    endtask

    task automatic t_mismatch();
        lvl_a = 3'd3; pulse_event_a();
        ack_lvl = 3'd5; iack_head = 1'b0; ds = 2'b01; step();
        check("R4 chain", {31'd0, chain}, 32'd0);
        check("R4 dtack", {31'd0, dtack_a}, 32'd1);
        ds = 2'b11; iack_head = 1'b1; step();
        check("R5 chain", {31'd0, chain}, 32'd1);
        check("R4 still pending", {25'd0, irq_a}, 32'h7b);
        step();
        ack_lvl = 3'd3; iack_head = 1'b0; ds = 2'b10; step();
        end_cycle();
    endtask

    task automatic t_no_pending();
        ack_lvl = 3'd3; iack_head = 1'b0; ds = 2'b10; step();
        check("R4 nopend chain", {31'd0, chain}, 32'd0);
        check("R4 nopend dtack", {31'd0, dtack_a}, 32'd1);
        end_cycle();
    endtask

    task automatic t_no_strobe();
        pulse_event_a();
        ack_lvl = 3'd3; iack_head = 1'b0; ds = 2'b11; step(); step();
        check("R12 chain", {31'd0, chain}, 32'd1);
        check("R12 dtack", {31'd0, dtack_a}, 32'd1);
        iack_head = 1'b1; step();
        iack_head = 1'b0; ds = 2'b10; step();
        end_cycle();
    endtask

    task automatic t_rora();
        roak_a = 1'b0; pulse_event_a();
        ack_lvl = 3'd3; iack_head = 1'b0; ds = 2'b10; step();
        check("R8 answered", {31'd0, dtack_a}, 32'd0);
        check("R8 kept", {25'd0, irq_a}, 32'h7b);
        end_cycle();
        check("R8 kept after", {25'd0, irq_a}, 32'h7b);
        clr_a = 1'b1; step(); clr_a = 1'b0;
        check("R8 cleared", {25'd0, irq_a}, 32'h7f);
    endtask

    task automatic t_roak_ignore_clr();
        roak_a = 1'b1; pulse_event_a();
        clr_a = 1'b1; step(); clr_a = 1'b0; step();
        check("R9 ignored", {25'd0, irq_a}, 32'h7b);
        ack_lvl = 3'd3; iack_head = 1'b0; ds = 2'b10; step();
        end_cycle();
    endtask

    task automatic t_same_cycle();
        roak_a = 1'b0; pulse_event_a();
        ev_a = 1'b1; clr_a = 1'b1; step(); ev_a = 1'b0; clr_a = 1'b0;
        check("R10 access", {25'd0, irq_a}, 32'h7b);
        clr_a = 1'b1; step(); clr_a = 1'b0;
        roak_a = 1'b1; pulse_event_a();
        ack_lvl = 3'd3; iack_head = 1'b0; ds = 2'b10; ev_a = 1'b1; step(); ev_a = 1'b0;
        check("R10 ack answered", {31'd0, dtack_a}, 32'd0);
        check("R10 ack kept", {25'd0, irq_a}, 32'h7b);
        end_cycle();
        ack_lvl = 3'd3; iack_head = 1'b0; ds = 2'b10; step();
        end_cycle();
    endtask

    task automatic t_daisy();
        lvl_a = 3'd4; lvl_b = 3'd4; roak_a = 1'b1; roak_b = 1'b1;
        vec_a = 8'h11; vec_b = 8'h22;
        ev_a = 1'b1; ev_b = 1'b1; step(); ev_a = 1'b0; ev_b = 1'b0;
        ack_lvl = 3'd4; iack_head = 1'b0; ds = 2'b10; step();
        check("R11 near answers", {24'd0, data_a}, 32'h11);
        check("R11 chain held", {31'd0, chain}, 32'd1);
        check("R11 far quiet", {31'd0, dtack_b}, 32'd1);
        end_cycle();
        check("R11 far pending", {25'd0, irq_b}, 32'h77);
        iack_head = 1'b0; ds = 2'b10; step();
        check("R11 near forwards", {31'd0, chain}, 32'd0);
        check("R11 far not yet", {31'd0, dtack_b}, 32'd1);
        step();
        check("R11 far answers", {31'd0, dtack_b}, 32'd0);
        check("R11 far vector", {24'd0, data_b}, 32'h22);
        check("R11 far end chain", {31'd0, chain_end}, 32'd1);
        end_cycle();
        check("R11 far cleared", {25'd0, irq_b}, 32'h7f);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_raise();
        t_ack_match();
        t_mismatch();
        t_no_pending();
        t_no_strobe();
        t_rora();
        t_roak_ignore_clr();
        t_same_cycle();
        t_daisy();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule